// File: doc/BRIEF.md
# Resumable Address-Range Cache Maintenance Sequencer

This block carries out a single cache maintenance instruction over a byte range of arbitrary length. The instruction names three registers. The destination register is read as the number of bytes to cover and is written back as work proceeds. The first source register gives the lowest address of the range and is only read. The second source register selects the maintenance kind. The block therefore needs one encoding for every kind.

The sequencer walks the range one cache line at a time, from the highest line down to the line that holds the start address. It hands each line to a cache controller over a valid/ready command port. After each accepted line, it writes the destination register with the number of bytes that still lie below that line. An interrupt request is looked at only in the gap between two line commands. When the block yields, the destination register holds all the progress made so far. Issuing the same instruction again, with the same registers, finishes the job exactly as an uninterrupted run would. Register reads and writes appear as plain ports.

Top module: `cmo_range_seq`

## Requirements
- R1: After reset the block is idle: `busy_o`, `cmd_valid_o`, `rd_we_o`, `done_o`, `stop_o` and `illegal_o` are all low.
- R2: The first line command goes out in the cycle after `start_i`. Each command carries the line-aligned address of (start + remaining − 1), where lines are LINE_BYTES (default 64) bytes. `cmd_op_o` carries the type: 0 for clean, 1 for flush and 2 for invalidate. Address and type stay unchanged while `cmd_ready_i` is low.
- R3: In the cycle after a line command is accepted, `rd_we_o` pulses. `rd_wdata_o` then equals that line's address minus the start address, or zero when the line lies at or below the start address.
- R4: Line commands continue at descending line addresses until the remaining count is zero. `done_o` then pulses for one cycle, in the cycle after the final register write of zero.
- R5: A count of zero completes with `done_o` in the cycle after `start_i`. No command is issued and no register is written.
- R6: Any type code other than 0, 1 or 2 pulses `illegal_o` in the cycle after `start_i`. No command is issued and no register is written.
- R7: `irq_i` is sampled only in the gap cycle that follows a register write with a nonzero count. In that case, `stop_o` pulses in the next cycle together with a rewrite of the same count, and the block returns to idle. `irq_i` has no effect while a command waits for `cmd_ready_i`. In the final gap, completion takes priority over the interrupt.
- R8: Re-issuing the instruction with the count written at a stop produces exactly the remaining line commands of the uninterrupted run.
- R9: `start_i` is ignored while the block is busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Instruction issue pulse |
| rd_val_i | input | ADDR_W | Destination register value: bytes to process |
| rs1_val_i | input | ADDR_W | First source value: start address |
| rs2_val_i | input | TYPE_W | Second source value: maintenance type code |
| irq_i | input | 1 | Pending interrupt request |
| cmd_ready_i | input | 1 | Cache controller accepts the line command |
| cmd_valid_o | output | 1 | Line command present |
| cmd_addr_o | output | ADDR_W | Line-aligned address of the command |
| cmd_op_o | output | 2 | Maintenance kind of the command |
| rd_we_o | output | 1 | Destination register write enable |
| rd_wdata_o | output | ADDR_W | Remaining byte count to write |
| done_o | output | 1 | Instruction completed |
| stop_o | output | 1 | Instruction yielded to an interrupt |
| illegal_o | output | 1 | Illegal-instruction request |
| busy_o | output | 1 | Instruction in progress |

## Verification
Completion and an interrupt can fall in the same gap cycle. This happens when the last line has just been accepted and `irq_i` is already high. The bench raises `irq_i` at the moment the final line is accepted and expects `done_o` with no `stop_o`. In a separate case, the bench raises `irq_i` at an earlier line and expects `stop_o` with the partial count. It then resumes from that count and compares the total of the two runs against the line count of one uninterrupted run.

// File: rtl/cmo_seq_pkg.sv
package cmo_seq_pkg;

  typedef enum logic [1:0] {
    OP_CLEAN = 2'd0,
    OP_FLUSH = 2'd1,
    OP_INVAL = 2'd2
  } cmo_op_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_GAP   = 2'd2
  } seq_state_e;

endpackage

// File: rtl/cmo_type_decode.sv
module cmo_type_decode
  import cmo_seq_pkg::*;
#(
  parameter int TYPE_W = 4
) (
  input  logic [TYPE_W-1:0] code_i,
  output logic              legal_o,
  output cmo_op_e           op_o
);

  function automatic logic code_known(input logic [TYPE_W-1:0] c);
    return c < TYPE_W'(3);
  endfunction

  always_comb begin
    legal_o = code_known(code_i);
    op_o    = OP_CLEAN;
    if (legal_o) op_o = cmo_op_e'(code_i[1:0]);
  end

endmodule

// File: rtl/cmo_line_calc.sv
module cmo_line_calc #(
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 64
) (
  input  logic [ADDR_W-1:0] base_i,
  input  logic [ADDR_W-1:0] remain_i,
  output logic [ADDR_W-1:0] line_addr_o,
  output logic [ADDR_W-1:0] next_remain_o
);

  localparam int OFF_W = $clog2(LINE_BYTES);
  localparam logic [ADDR_W-1:0] OFF_MASK = ADDR_W'(LINE_BYTES - 1);

  function automatic logic [ADDR_W-1:0] top_byte(input logic [ADDR_W-1:0] b,
                                                  input logic [ADDR_W-1:0] n);
    return b + n - ADDR_W'(1);
  endfunction

  function automatic logic [ADDR_W-1:0] align_down(input logic [ADDR_W-1:0] a);
    return a & ~OFF_MASK;
  endfunction

  // Bytes below the chosen line, clamped at zero; wrap-safe form.
  function automatic logic [ADDR_W-1:0] below_line(input logic [ADDR_W-1:0] top,
                                                    input logic [ADDR_W-1:0] n);
    logic [ADDR_W-1:0] low;
    low = top & OFF_MASK;
    if (low >= n) return '0;
    return n - ADDR_W'(1) - low;
  endfunction

  logic [ADDR_W-1:0] top_addr;

  always_comb begin
    top_addr      = top_byte(base_i, remain_i);
    line_addr_o   = align_down(top_addr);
    next_remain_o = below_line(top_addr, remain_i);
  end

  if (OFF_W < 1) begin : g_bad_line
    initial $error("LINE_BYTES must be at least 2");
  end

endmodule

// File: rtl/cmo_seq_ctrl.sv
module cmo_seq_ctrl
  import cmo_seq_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] count_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              legal_i,
  input  cmo_op_e           op_i,
  input  logic              irq_i,
  input  logic              cmd_ready_i,
  input  logic [ADDR_W-1:0] next_remain_i,
  output logic [ADDR_W-1:0] base_o,
  output logic [ADDR_W-1:0] remain_o,
  output cmo_op_e           op_o,
  output logic              cmd_valid_o,
  output logic              rd_we_o,
  output logic [ADDR_W-1:0] rd_wdata_o,
  output logic              done_o,
  output logic              stop_o,
  output logic              illegal_o,
  output logic              busy_o,
  output logic              accept_o,
  output logic              gap_o
);

  seq_state_e state_q;

  always_comb begin
    cmd_valid_o = (state_q == ST_ISSUE);
    busy_o      = (state_q != ST_IDLE);
    accept_o    = cmd_valid_o && cmd_ready_i;
    gap_o       = (state_q == ST_GAP);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      base_o     <= '0;
      remain_o   <= '0;
      op_o       <= OP_CLEAN;
      rd_we_o    <= 1'b0;
      rd_wdata_o <= '0;
      done_o     <= 1'b0;
      stop_o     <= 1'b0;
      illegal_o  <= 1'b0;
    end else begin
      rd_we_o   <= 1'b0;
      done_o    <= 1'b0;
      stop_o    <= 1'b0;
      illegal_o <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            if (!legal_i) begin
              illegal_o <= 1'b1;
            end else if (count_i == '0) begin
              done_o <= 1'b1;
            end else begin
              base_o   <= addr_i;
              remain_o <= count_i;
              op_o     <= op_i;
              state_q  <= ST_ISSUE;
            end
          end
        end
        ST_ISSUE: begin
          if (cmd_ready_i) begin
            remain_o   <= next_remain_i;
            rd_we_o    <= 1'b1;
            rd_wdata_o <= next_remain_i;
            state_q    <= ST_GAP;
          end
        end
        ST_GAP: begin
          if (remain_o == '0) begin
            done_o  <= 1'b1;
            state_q <= ST_IDLE;
          end else if (irq_i) begin
            stop_o     <= 1'b1;
            rd_we_o    <= 1'b1;
            rd_wdata_o <= remain_o;
            state_q    <= ST_IDLE;
          end else begin
            state_q <= ST_ISSUE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/cmo_range_seq.sv
module cmo_range_seq
  import cmo_seq_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 64,
  parameter int TYPE_W     = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] rd_val_i,
  input  logic [ADDR_W-1:0] rs1_val_i,
  input  logic [TYPE_W-1:0] rs2_val_i,
  input  logic              irq_i,
  input  logic              cmd_ready_i,
  output logic              cmd_valid_o,
  output logic [ADDR_W-1:0] cmd_addr_o,
  output logic [1:0]        cmd_op_o,
  output logic              rd_we_o,
  output logic [ADDR_W-1:0] rd_wdata_o,
  output logic              done_o,
  output logic              stop_o,
  output logic              illegal_o,
  output logic              busy_o
);

  logic              type_legal;
  cmo_op_e           type_op;
  cmo_op_e           held_op;
  logic [ADDR_W-1:0] base_q;
  logic [ADDR_W-1:0] remain_q;
  logic [ADDR_W-1:0] line_addr;
  logic [ADDR_W-1:0] next_remain;
  logic              line_accept;
  logic              gap_cycle;

  cmo_type_decode #(.TYPE_W(TYPE_W)) u_decode (
    .code_i (rs2_val_i),
    .legal_o(type_legal),
    .op_o   (type_op)
  );

  cmo_line_calc #(.ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES)) u_calc (
    .base_i       (base_q),
    .remain_i     (remain_q),
    .line_addr_o  (line_addr),
    .next_remain_o(next_remain)
  );

  cmo_seq_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start_i),
    .count_i      (rd_val_i),
    .addr_i       (rs1_val_i),
    .legal_i      (type_legal),
    .op_i         (type_op),
    .irq_i        (irq_i),
    .cmd_ready_i  (cmd_ready_i),
    .next_remain_i(next_remain),
    .base_o       (base_q),
    .remain_o     (remain_q),
    .op_o         (held_op),
    .cmd_valid_o  (cmd_valid_o),
    .rd_we_o      (rd_we_o),
    .rd_wdata_o   (rd_wdata_o),
    .done_o       (done_o),
    .stop_o       (stop_o),
    .illegal_o    (illegal_o),
    .busy_o       (busy_o),
    .accept_o     (line_accept),
    .gap_o        (gap_cycle)
  );

  assign cmd_addr_o = line_addr;
  assign cmd_op_o   = held_op;

endmodule

// File: rtl/cmo_range_seq_chk.sv
module cmo_range_seq_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start_i,
  input logic              irq_i,
  input logic              cmd_ready_i,
  input logic              cmd_valid_o,
  input logic [ADDR_W-1:0] cmd_addr_o,
  input logic [1:0]        cmd_op_o,
  input logic              rd_we_o,
  input logic [ADDR_W-1:0] rd_wdata_o,
  input logic              done_o,
  input logic              stop_o,
  input logic              illegal_o,
  input logic              busy_o,
  input logic              line_accept,
  input logic              gap_cycle,
  input logic [ADDR_W-1:0] remain_q,
  input logic [ADDR_W-1:0] base_q
);

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> !cmd_valid_o); // R1

  AST_HOLD_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid_o && !cmd_ready_i |=> cmd_valid_o && $stable(cmd_addr_o) && $stable(cmd_op_o)); // R2

  AST_WRITE_AFTER_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    line_accept |=> rd_we_o); // R3

  AST_COUNT_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    line_accept |=> rd_wdata_o < $past(remain_q)); // R3

  AST_CMD_HAS_WORK: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid_o |-> remain_q != '0); // R4

  AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({done_o, stop_o, illegal_o})); // R4

  AST_ILLEGAL_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_o |-> !rd_we_o && !busy_o); // R6

  AST_STOP_FROM_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    stop_o |-> $past(gap_cycle && irq_i)); // R7

  AST_DONE_BEATS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    gap_cycle && remain_q == '0 |=> done_o && !stop_o); // R7

  AST_BUSY_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o && start_i |=> $stable(base_q)); // R9

endmodule

bind cmo_range_seq cmo_range_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .start_i    (start_i),
  .irq_i      (irq_i),
  .cmd_ready_i(cmd_ready_i),
  .cmd_valid_o(cmd_valid_o),
  .cmd_addr_o (cmd_addr_o),
  .cmd_op_o   (cmd_op_o),
  .rd_we_o    (rd_we_o),
  .rd_wdata_o (rd_wdata_o),
  .done_o     (done_o),
  .stop_o     (stop_o),
  .illegal_o  (illegal_o),
  .busy_o     (busy_o),
  .line_accept(line_accept),
  .gap_cycle  (gap_cycle),
  .remain_q   (remain_q),
  .base_q     (base_q)
);

// File: tb/cmo_range_seq_bench.sv
module cmo_range_seq_bench;

  localparam int LB = 64;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [31:0] rd_val_i = '0;
  logic [31:0] rs1_val_i = '0;
  logic [3:0]  rs2_val_i = '0;
  logic        irq_i = 1'b0;
  logic        cmd_ready_i = 1'b1;
  logic        cmd_valid_o;
  logic [31:0] cmd_addr_o;
  logic [1:0]  cmd_op_o;
  logic        rd_we_o;
  logic [31:0] rd_wdata_o;
  logic        done_o, stop_o, illegal_o, busy_o;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  cmo_range_seq u_cmo_range_seq (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .rd_val_i(rd_val_i),
    .rs1_val_i(rs1_val_i), .rs2_val_i(rs2_val_i), .irq_i(irq_i),
    .cmd_ready_i(cmd_ready_i), .cmd_valid_o(cmd_valid_o), .cmd_addr_o(cmd_addr_o),
    .cmd_op_o(cmd_op_o), .rd_we_o(rd_we_o), .rd_wdata_o(rd_wdata_o),
    .done_o(done_o), .stop_o(stop_o), .illegal_o(illegal_o), .busy_o(busy_o)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  // Model: lines counted as whole-line indices, no wrap in the test ranges.
  function automatic longint m_line(input longint b, input longint n);
    return ((b + n - 1) / LB) * LB;
  endfunction
  function automatic longint m_left(input longint b, input longint n);
    longint l;
    l = m_line(b, n);
    return (l > b) ? l - b : 0;
  endfunction
  function automatic int m_lines(input longint b, input longint n);
    if (n == 0) return 0;
    return int'((b + n - 1) / LB - b / LB + 1);
  endfunction

  // status: 1 done, 2 stop, 3 illegal, 0 none
  task automatic run_op(input longint base, input longint cnt, input logic [3:0] typ,
                        input int irq_at, input int stall, input bit poke,
                        output int n_lines, output int status, output longint last_wr);
    longint mcnt;
    longint exp_wr;
    bit     prev_zero_wr;
    int     st;
    mcnt = cnt; exp_wr = 0; prev_zero_wr = 0; st = stall;
    n_lines = 0; status = 0; last_wr = cnt;
    @(negedge clk);
    start_i = 1; rs1_val_i = base[31:0]; rd_val_i = cnt[31:0]; rs2_val_i = typ;
    @(negedge clk);
    start_i = 0;
    for (int cyc = 0; cyc < 3000 && status == 0; cyc++) begin
      if (poke && cyc == 1) begin
        start_i = 1; rd_val_i = 32'd0; rs1_val_i = 32'hFFFF_0000; rs2_val_i = 4'd9;
      end else if (poke && cyc == 2) begin
        start_i = 0;
      end
      if (rd_we_o) begin
        chk(rd_wdata_o == exp_wr[31:0], "R3", "count write", rd_wdata_o, exp_wr);
        last_wr = rd_wdata_o;
      end
      if (done_o) begin
        status = 1;
        if (cnt == 0) chk(cyc == 0, "R5", "done timing", cyc, 0);
        else chk(prev_zero_wr, "R4", "done follows zero write", prev_zero_wr, 1);
        chk(!rd_we_o, "R4", "no write with done", rd_we_o, 0);
      end
      if (stop_o) begin
        status = 2;
        chk(rd_we_o && rd_wdata_o == mcnt[31:0], "R7", "stop rewrites count", rd_wdata_o, mcnt);
      end
      if (illegal_o) begin
        status = 3;
        chk(cyc == 0 && !rd_we_o, "R6", "illegal timing", cyc, 0);
      end
      prev_zero_wr = rd_we_o && rd_wdata_o == 0;
      if (cmd_valid_o) begin
        chk(cmd_addr_o == m_line(base, mcnt), "R2", "line address", cmd_addr_o, m_line(base, mcnt));
        chk(cmd_op_o == typ[1:0], "R2", "op code", cmd_op_o, typ[1:0]);
        if (st > 0) begin
          cmd_ready_i = 0; irq_i = 1; st--;
        end else begin
          cmd_ready_i = 1; irq_i = 0;
          exp_wr = m_left(base, mcnt);
          mcnt = exp_wr;
          n_lines++;
          if (n_lines == irq_at) irq_i = 1;
        end
      end
      @(negedge clk);
    end
    irq_i = 0; cmd_ready_i = 1;
    chk(!busy_o && !cmd_valid_o, "R4", "idle after end", busy_o, 0);
  endtask

  task automatic t_reset();
    chk(!busy_o && !cmd_valid_o && !rd_we_o, "R1", "idle outputs", {busy_o, cmd_valid_o, rd_we_o}, 0);
    chk(!done_o && !stop_o && !illegal_o, "R1", "no events", {done_o, stop_o, illegal_o}, 0);
  endtask

  task automatic t_aligned();
    int n, s; longint w;
    run_op(64'h1000, 256, 4'd0, 0, 0, 0, n, s, w);
    chk(n == 4, "R4", "aligned line count", n, 4);
    chk(s == 1 && w == 0, "R4", "aligned done", s, 1);
  endtask

  task automatic t_unaligned();
    int n, s; longint w;
    run_op(64'h1010, 100, 4'd1, 0, 0, 0, n, s, w);
    chk(n == m_lines(64'h1010, 100), "R4", "unaligned line count", n, m_lines(64'h1010, 100));
    chk(s == 1, "R3", "unaligned done", s, 1);
    run_op(64'h2005, 3, 4'd2, 0, 0, 0, n, s, w);
    chk(n == 1 && s == 1, "R4", "single line", n, 1);
  endtask

  task automatic t_zero();
    int n, s; longint w;
    run_op(64'h4000, 0, 4'd1, 0, 0, 0, n, s, w);
    chk(n == 0 && s == 1, "R5", "zero count", n, 0);
  endtask

  task automatic t_illegal();
    int n, s; longint w;
    run_op(64'h4000, 128, 4'd7, 0, 0, 0, n, s, w);
    chk(n == 0 && s == 3, "R6", "type 7", s, 3);
    run_op(64'h4000, 128, 4'd3, 0, 0, 0, n, s, w);
    chk(n == 0 && s == 3, "R6", "type 3", s, 3);
  endtask

  task automatic t_stall_irq();
    int n, s; longint w;
    run_op(64'h0, 192, 4'd2, 0, 3, 0, n, s, w);
    chk(n == 3 && s == 1, "R7", "irq during stall ignored", s, 1);
  endtask

  task automatic t_resume();
    int n1, s1, n2, s2; longint w1, w2;
    run_op(64'h3000, 320, 4'd1, 2, 0, 0, n1, s1, w1);
    chk(s1 == 2, "R7", "stop status", s1, 2);
    chk(n1 == 2 && w1 == 192, "R7", "stop count", w1, 192);
    run_op(64'h3000, w1, 4'd1, 0, 0, 0, n2, s2, w2);
    chk(s2 == 1 && n1 + n2 == m_lines(64'h3000, 320), "R8", "resume total lines", n1 + n2, m_lines(64'h3000, 320));
  endtask

  task automatic t_irq_last();
    int n, s; longint w;
    run_op(64'h5020, 130, 4'd0, m_lines(64'h5020, 130), 0, 0, n, s, w);
    chk(s == 1, "R7", "done wins over irq", s, 1);
  endtask

  task automatic t_busy_start();
    int n, s; longint w;
    run_op(64'h6000, 256, 4'd0, 0, 0, 1, n, s, w);
    chk(n == 4 && s == 1, "R9", "busy start ignored", n, 4);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_aligned();
    t_unaligned();
    t_zero();
    t_illegal();
    t_stall_irq();
    t_resume();
    t_irq_last();
    t_busy_start();
    repeat (2) @(negedge clk);
    summary();
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    summary();
    $finish;
  end

endmodule